// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block is a single timer channel that holds an output high for a programmed number of count-source periods each time it is triggered, and then drops it and raises a one-cycle interrupt request. A small register-style interface sets it up: a mode byte picks the count-source divider, the trigger source and the trigger edge, and a 16-bit data write port loads the pulse length. A count-enable level gates the whole function, and a software start strobe provides a trigger when the external pin is not selected.

The count source comes from an internal prescaler. It divides the system clock by 2, 16, 64 or 512 and restarts its phase on every accepted trigger, so a pulse lasts an exact number of system clocks. A trigger that arrives while a pulse is running reloads the counter from the reload register and extends the pulse. A trigger that arrives while the timer is idle counts down from whatever value the counter already holds. The counter cannot be read back.

Top module: `oneshot_timer`

## Requirements
- R1: The mode error flag is 1 while mode bit 0 or bit 5 is 1, or while bit 1 or bit 2 is 0. It updates on the clock edge that writes the mode. While the flag is 1, every trigger is ignored. The reset mode value 0x06 is legal: software trigger, divide by 2.
- R2: When mode bit 4 is 0, a one-cycle software start strobe is the trigger, and the output is high from the edge that samples the strobe. When bit 4 is 1, the software strobe is ignored and the external pin is the trigger. Bit 3 picks the pin edge: 1 means rising, 0 means falling. The pin passes through two synchronizer flops, so the output rises on the third clock edge after the pin changes.
- R3: Mode bits 7:6 select the count-source divider: 00 divides by 2, 01 by 16, 10 by 64 and 11 by 512. A pulse started from an idle timer whose counter holds N stays high for exactly N times the divider in system clocks.
- R4: While count-enable is 0, the output is low from the next clock edge onward and triggers are ignored.
- R5: At the end of a pulse, the output falls and the interrupt request is high for exactly one cycle, on the same edge. The counter is then loaded from the reload register, so a later trigger repeats the same width.
- R6: A trigger on an idle timer does not reload the counter. If a pulse is cut short by clearing count-enable, the next pulse runs for the remaining count.
- R7: A retrigger during a pulse, at least one count-source tick after the previous accepted trigger, reloads the counter. The output then stays high for the reload value times the divider, counted from that retrigger.
- R8: A retrigger before the first count-source tick since the previous accepted trigger is ignored.
- R9: A data write during a pulse changes only the reload register. The running pulse keeps its width, and the next pulse uses the new value.
- R10: A data write while the timer is idle loads both the reload register and the counter.
- R11: A trigger while the counter holds zero leaves the output low and raises no interrupt.
- R12: The data read port always returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | Mode byte value |
| data_we | input | 1 | Timer data write strobe |
| data_wdata | input | 16 | Timer data value |
| data_rdata | output | 16 | Timer data read value, always all ones |
| cnt_en | input | 1 | Count-enable level |
| sw_start | input | 1 | One-cycle software trigger strobe |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| pulse_out | output | 1 | One-shot output |
| irq | output | 1 | One-cycle end-of-pulse interrupt request |
| mode_err | output | 1 | Illegal mode byte flag |

## Verification
A wrong counter or reload value shows up as a pulse that is too long or too short, so every pulse width is measured to the exact system clock. A single-cycle error is therefore caught at the falling edge of the first affected pulse. A stuck running state or a lost tick-seen flag shows up as a missing or extra interrupt, or as a retrigger that extends the pulse when it should not. A stale counter after a pulse ends shows up only on the next trigger, so each width check is followed by a repeat trigger that has no data write in between.

// File: rtl/ost_pkg.sv
package ost_pkg;

  localparam int PRE_W = 9;

  typedef enum logic [1:0] {
    CS_DIV2   = 2'b00,
    CS_DIV16  = 2'b01,
    CS_DIV64  = 2'b10,
    CS_DIV512 = 2'b11
  } clk_sel_e;

  typedef struct packed {
    clk_sel_e clk_sel;
    logic     must0_hi;
    logic     pin_src;
    logic     rise_edge;
    logic     must1_hi;
    logic     must1_lo;
    logic     must0_lo;
  } mode_t;

  localparam mode_t MODE_RESET = 8'h06;

  function automatic logic mode_bad(input mode_t m);
    return m.must0_lo | m.must0_hi | ~m.must1_lo | ~m.must1_hi;
  endfunction

  function automatic logic [PRE_W-1:0] div_limit(input clk_sel_e s);
    case (s)
      CS_DIV2:   return PRE_W'(1);
      CS_DIV16:  return PRE_W'(15);
      CS_DIV64:  return PRE_W'(63);
      default:   return PRE_W'(511);
    endcase
  endfunction

endpackage

// File: rtl/ost_prescaler.sv
module ost_prescaler
  import ost_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     restart,
  input  clk_sel_e sel,
  output logic     tick
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;

  assign lim  = W'(div_limit(sel));
  assign tick = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ost_trigger.sv
module ost_trigger #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic sw_start,
  input  logic pin_src,
  input  logic rise_edge,
  output logic trig
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic            cur;
  logic            prev;
  logic            pin_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[SH_W-2:0], pin};
    end
  end

  assign cur      = sh_q[SYNC_STAGES-1];
  assign prev     = sh_q[SYNC_STAGES];
  assign pin_edge = rise_edge ? (cur & ~prev) : (~cur & prev);
  assign trig     = pin_src ? pin_edge : sw_start;

endmodule

// File: rtl/ost_core.sv
module ost_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             trig,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic             restart,
  output logic             pulse,
  output logic             irq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             run_q;
  logic             seen_q;
  logic             irq_q;
  logic             retrig_go;
  logic             start_go;

  assign retrig_go = en && trig && run_q && seen_q;
  assign start_go  = en && trig && !run_q && (count_q != '0);
  assign restart   = retrig_go || start_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= '0;
      run_q    <= 1'b0;
      seen_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_en) begin
        reload_q <= wr_data;
      end
      if (!en) begin
        run_q <= 1'b0;
      end else if (retrig_go) begin
        seen_q <= 1'b0;
        if (reload_q == '0) begin
          run_q   <= 1'b0;
          count_q <= '0;
        end else begin
          count_q <= reload_q;
        end
      end else if (start_go) begin
        run_q  <= 1'b1;
        seen_q <= 1'b0;
      end else if (run_q && tick) begin
        seen_q <= 1'b1;
        if (count_q == ONE) begin
          count_q <= reload_q;
          run_q   <= 1'b0;
          irq_q   <= 1'b1;
        end else begin
          count_q <= count_q - ONE;
        end
      end
      if (wr_en && !run_q) begin
        count_q <= wr_data;
      end
    end
  end

  assign pulse = run_q;
  assign irq   = irq_q;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import ost_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic [7:0]       mode_wdata,
  input  logic             data_we,
  input  logic [CNT_W-1:0] data_wdata,
  output logic [CNT_W-1:0] data_rdata,
  input  logic             cnt_en,
  input  logic             sw_start,
  input  logic             trig_pin,
  output logic             pulse_out,
  output logic             irq,
  output logic             mode_err
);

  mode_t mode_q;
  logic  err_q;
  logic  trig;
  logic  tick;
  logic  restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RESET;
      err_q  <= 1'b0;
    end else if (mode_we) begin
      mode_q <= mode_t'(mode_wdata);
      err_q  <= mode_bad(mode_t'(mode_wdata));
    end
  end

  ost_trigger #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_trig (
    .clk      (clk),
    .rst      (rst),
    .pin      (trig_pin),
    .sw_start (sw_start),
    .pin_src  (mode_q.pin_src),
    .rise_edge(mode_q.rise_edge),
    .trig     (trig)
  );

  ost_prescaler #(
    .W(PRE_W)
  ) u_pre (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .sel    (mode_q.clk_sel),
    .tick   (tick)
  );

  ost_core #(
    .CNT_W(CNT_W)
  ) u_core (
    .clk    (clk),
    .rst    (rst),
    .en     (cnt_en),
    .trig   (trig && !err_q),
    .tick   (tick),
    .wr_en  (data_we),
    .wr_data(data_wdata),
    .restart(restart),
    .pulse  (pulse_out),
    .irq    (irq)
  );

  assign mode_err   = err_q;
  assign data_rdata = '1;

endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             pulse_out,
  input logic             irq,
  input logic             mode_err,
  input logic [CNT_W-1:0] data_rdata
);

  a_r4_off_forces_low: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> !pulse_out);

  a_r5_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  a_r5_irq_at_fall: assert property (@(posedge clk) disable iff (rst)
    irq |-> $fell(pulse_out));

  a_r1_err_blocks_start: assert property (@(posedge clk) disable iff (rst)
    (mode_err && !pulse_out) |=> !pulse_out);

  a_r12_rdata_ones: assert property (@(posedge clk) disable iff (rst)
    data_rdata == '1);

endmodule

bind oneshot_timer oneshot_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_en    (cnt_en),
  .pulse_out (pulse_out),
  .irq       (irq),
  .mode_err  (mode_err),
  .data_rdata(data_rdata)
);

// File: tb/oneshot_timer_bench.sv
`timescale 1ns/1ps
module oneshot_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_we = 1'b0;
  logic [7:0]  mode_wdata = 8'h00;
  logic        data_we = 1'b0;
  logic [15:0] data_wdata = 16'h0000;
  logic [15:0] data_rdata;
  logic        cnt_en = 1'b1;
  logic        sw_start = 1'b0;
  logic        trig_pin = 1'b0;
  logic        pulse_out;
  logic        irq;
  logic        mode_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  oneshot_timer u_oneshot_timer (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .cnt_en(cnt_en), .sw_start(sw_start), .trig_pin(trig_pin),
    .pulse_out(pulse_out), .irq(irq), .mode_err(mode_err)
  );

  // mode byte, data word
  localparam logic [23:0] VEC [7] = '{
    {8'h06, 16'd5},
    {8'h46, 16'd3},
    {8'h86, 16'd2},
    {8'hC6, 16'd1},
    {8'h06, 16'd1},
    {8'h06, 16'd0},
    {8'h46, 16'h0100}
  };

  function automatic int div_of(input logic [1:0] s);
    case (s)
      2'b00:   return 2;
      2'b01:   return 16;
      2'b10:   return 64;
      default: return 512;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_data(input logic [15:0] d);
    @(negedge clk); data_we = 1'b1; data_wdata = d;
    @(negedge clk); data_we = 1'b0;
  endtask

  // software trigger, optional retrigger and data write at sample index
  task automatic fire(input int retrig_at, input int wr_at, input logic [15:0] wr_val,
                      output int width, output int irqs);
    width = 0; irqs = 0;
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    for (int i = 1; i < 20000; i++) begin
      if (irq) irqs++;
      if (!pulse_out) break;
      width++;
      sw_start   = (i == retrig_at);
      data_we    = (i == wr_at);
      data_wdata = wr_val;
      @(negedge clk);
    end
    sw_start = 1'b0; data_we = 1'b0;
    @(negedge clk);
    if (irq) irqs++;
  endtask

  initial begin
    #(190000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int w, q, exp_w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pulse_out == 1'b0, "R4 reset out", pulse_out, 0);
    chk(irq == 1'b0, "R5 reset irq", irq, 0);
    chk(mode_err == 1'b0, "R1 reset mode legal", mode_err, 0);
    chk(data_rdata == 16'hFFFF, "R12 rdata", data_rdata, 16'hFFFF);

    // table walk: R3 widths, R10 idle write, R11 zero count
    foreach (VEC[k]) begin
      wr_mode(VEC[k][23:16]);
      wr_data(VEC[k][15:0]);
      exp_w = int'(VEC[k][15:0]) * div_of(VEC[k][23:22]);
      fire(-1, -1, 16'h0, w, q);
      chk(w == exp_w, "R3/R10/R11 width", w, exp_w);
      chk(q == ((VEC[k][15:0] != 0) ? 1 : 0), "R5/R11 irq count", q, (VEC[k][15:0] != 0) ? 1 : 0);
    end

    // R5 reload after end: repeat without write
    wr_mode(8'h06); wr_data(16'd4);
    fire(-1, -1, 16'h0, w, q);
    fire(-1, -1, 16'h0, w, q);
    chk(w == 8, "R5 repeat width", w, 8);
    chk(q == 1, "R5 repeat irq", q, 1);

    // R7 accepted retrigger
    fire(3, -1, 16'h0, w, q);
    chk(w == 11, "R7 retrigger extends", w, 11);
    chk(q == 1, "R7 irq once", q, 1);
    // R8 early retrigger ignored
    fire(1, -1, 16'h0, w, q);
    chk(w == 8, "R8 early retrigger", w, 8);

    // R9 write while running
    wr_data(16'd6);
    fire(-1, 3, 16'd2, w, q);
    chk(w == 12, "R9 running width kept", w, 12);
    fire(-1, -1, 16'h0, w, q);
    chk(w == 4, "R9 next uses new reload", w, 4);

    // R6 cut short then resume from remaining count
    wr_data(16'd10);
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    repeat (6) @(negedge clk);
    chk(pulse_out == 1'b1, "R6 still high", pulse_out, 1);
    cnt_en = 1'b0;
    @(negedge clk);
    chk(pulse_out == 1'b0, "R4 disable forces low", pulse_out, 0);
    chk(irq == 1'b0, "R4 no irq on disable", irq, 0);
    fire(-1, -1, 16'h0, w, q);
    chk(w == 0, "R4 trigger ignored when off", w, 0);
    cnt_en = 1'b1;
    fire(-1, -1, 16'h0, w, q);
    chk(w == 14, "R6 idle trigger no reload", w, 14);

    // R1 mode error
    wr_mode(8'h07);
    chk(mode_err == 1'b1, "R1 bit0 set", mode_err, 1);
    fire(-1, -1, 16'h0, w, q);
    chk(w == 0, "R1 trigger blocked", w, 0);
    wr_mode(8'h02);
    chk(mode_err == 1'b1, "R1 bit2 clear", mode_err, 1);
    wr_mode(8'h26);
    chk(mode_err == 1'b1, "R1 bit5 set", mode_err, 1);

    // R2 pin rising mode
    wr_mode(8'h1E);
    chk(mode_err == 1'b0, "R1 legal pin mode", mode_err, 0);
    wr_data(16'd3);
    fire(-1, -1, 16'h0, w, q);
    chk(w == 0, "R2 sw ignored in pin mode", w, 0);
    @(negedge clk); trig_pin = 1'b1;
    @(negedge clk); chk(pulse_out == 1'b0, "R2 sync stage1", pulse_out, 0);
    @(negedge clk); chk(pulse_out == 1'b0, "R2 sync stage2", pulse_out, 0);
    @(negedge clk); chk(pulse_out == 1'b1, "R2 rising edge start", pulse_out, 1);
    repeat (10) @(negedge clk);
    trig_pin = 1'b0;
    repeat (6) @(negedge clk);
    chk(pulse_out == 1'b0, "R2 falling ignored in rise mode", pulse_out, 0);

    // R2 pin falling mode
    wr_mode(8'h16);
    @(negedge clk); trig_pin = 1'b1;
    repeat (5) @(negedge clk);
    chk(pulse_out == 1'b0, "R2 rising ignored in fall mode", pulse_out, 0);
    trig_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); chk(pulse_out == 1'b1, "R2 falling edge start", pulse_out, 1);
    repeat (10) @(negedge clk);
    chk(data_rdata == 16'hFFFF, "R12 rdata late", data_rdata, 16'hFFFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule